// File: doc/BRIEF.md
# Auto-Reload PWM Timer

A down-counter works with a single reload register to drive a pulse-width-modulated level on one output pin. Before the timer starts, the pin sits high, the counter holds the high-phase length and the reload register holds the low-phase length. With the run bit set, the counter steps down once per cycle-enable tick. When it reaches zero and one more tick arrives, an underflow occurs. The underflow inverts the pin and copies the reload register into the counter, which goes on counting with no restart.

Each underflow also raises a pending-interrupt flag. Software then writes the length of the phase after the current one into the reload register. A stream of alternating on and off lengths gives a continuous PWM wave. A value N gives a phase of N+1 ticks.

Top module: `pwm_autoreload_timer`

## Requirements
- R1: After synchronous reset, pwm_out is 1, irq_pend is 0, and both the counter and the reload register hold 0.
- R2: A timer write loads the counter with the written value. It takes priority over counting, so no underflow happens in a cycle that carries a timer write.
- R3: With run high, each cycle with tick high lowers a nonzero counter by one. A counter loaded with N keeps its phase for N+1 ticks.
- R4: An underflow inverts pwm_out on the next clock edge. An underflow is a cycle with run high, tick high, counter at 0 and no timer write. pwm_out changes at no other time apart from reset.
- R5: On underflow the counter takes the reload value in place of wrapping, and it keeps counting with no further action.
- R6: Every underflow sets irq_pend. A pulse on irq_clr clears it. If both happen in the same cycle, the set wins.
- R7: While run is low, the counter and pwm_out hold their values, whatever the tick input does.
- R8: A cycle with tick low changes neither the counter nor pwm_out.
- R9: A reload write in the same cycle as an underflow supplies the value loaded by that underflow.
- R10: A reload write while counting does not alter the phase in progress. It only sets the length of the next phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Cycle-enable; the counter moves only on ticks |
| run | input | 1 | Run bit; low freezes counter and pin |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | CNT_W | Value written into the counter |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | CNT_W | Value written into the reload register |
| irq_clr | input | 1 | Clears the pending interrupt flag |
| pwm_out | output | 1 | PWM output pin, registered |
| irq_pend | output | 1 | Underflow interrupt pending, registered |

## Verification
Two pairs of events can land in the same cycle. The first is an underflow together with a software write to the reload register. The bench produces it by starting the timer at zero and writing the reload register in the cycle where run first goes high. It passes only if the next low phase lasts the newly written length plus one tick, not the old one. The second is an underflow together with an interrupt clear. It occurs in the zero-length-phase vectors, and irq_pend must stay set there. A third pair is a timer write landing on a zero count. It must suppress the toggle, and this is judged from the length of the high phase that follows.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned DEF_CNT_W = 8;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } pin_lvl_e;
endpackage

// File: rtl/pwm_reload_reg.sv
module pwm_reload_reg #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] next_val
);
  logic [CNT_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)     hold_q <= '0;
    else if (we) hold_q <= wdata;
  end

  // a write in the same cycle is visible to a reload in that cycle
  assign next_val = we ? wdata : hold_q;

  // R10
  reload_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(hold_q));
endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step      = run && tick && !load;
  assign underflow = step && (cnt_q == ZERO);

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= ZERO;
    else if (load)      cnt_q <= load_val;
    else if (underflow) cnt_q <= reload_val;
    else if (step)      cnt_q <= cnt_q - ONE;
  end

  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(load_val));

  // R3
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_q != ZERO) |=> cnt_q == $past(cnt_q) - ONE);

  // R5
  reload_on_uf_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |=> cnt_q == $past(reload_val));

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt_q));

  // R8
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_phase_out.sv
module pwm_phase_out
  import pwm_timer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic underflow,
  input  logic irq_clr,
  output logic pin,
  output logic irq
);
  pin_lvl_e lvl_q;
  logic     irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= LVL_HIGH;
      irq_q <= 1'b0;
    end else begin
      if (underflow) lvl_q <= (lvl_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
      if (underflow)    irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign pin = (lvl_q == LVL_HIGH);
  assign irq = irq_q;

  // R4
  toggle_on_uf_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |=> pin != $past(pin));

  // R4
  pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !underflow |=> $stable(pin));

  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |=> irq);

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !underflow) |=> !irq);
endmodule

// File: rtl/pwm_autoreload_timer.sv
module pwm_autoreload_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             tmr_we,
  input  logic [CNT_W-1:0] tmr_wdata,
  input  logic             rld_we,
  input  logic [CNT_W-1:0] rld_wdata,
  input  logic             irq_clr,
  output logic             pwm_out,
  output logic             irq_pend
);
  logic [CNT_W-1:0] reload_val;
  logic             uf;

  pwm_reload_reg #(.CNT_W(CNT_W)) u_rld (
    .clk      (clk),
    .rst      (rst),
    .we       (rld_we),
    .wdata    (rld_wdata),
    .next_val (reload_val)
  );

  pwm_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .run        (run),
    .load       (tmr_we),
    .load_val   (tmr_wdata),
    .reload_val (reload_val),
    .underflow  (uf)
  );

  pwm_phase_out u_out (
    .clk       (clk),
    .rst       (rst),
    .underflow (uf),
    .irq_clr   (irq_clr),
    .pin       (pwm_out),
    .irq       (irq_pend)
  );
endmodule

// File: tb/sim_pwm_autoreload_timer.sv
module sim_pwm_autoreload_timer;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, tick, run, tmr_we, rld_we, irq_clr;
  logic [W-1:0] tmr_wdata, rld_wdata;
  logic pwm_out, irq_pend;
  logic half = 1'b0;
  int   n_chk = 0, n_bad = 0, cyc = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pwm_autoreload_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .run(run),
    .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
    .rld_we(rld_we), .rld_wdata(rld_wdata),
    .irq_clr(irq_clr), .pwm_out(pwm_out), .irq_pend(irq_pend)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // {on length, off length}
  localparam logic [15:0] VEC [0:5] = '{
    16'h0305, 16'h0000, 16'h0A01, 16'h0107, 16'hFF02, 16'h0410
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b0; run = 1'b0; tmr_we = 1'b0; rld_we = 1'b0;
    irq_clr = 1'b0; tmr_wdata = '0; rld_wdata = '0; half = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic preload(input logic [W-1:0] on_v, input logic [W-1:0] off_v);
    tmr_we = 1'b1; tmr_wdata = on_v; rld_we = 1'b1; rld_wdata = off_v;
    @(negedge clk);
    tmr_we = 1'b0; rld_we = 1'b0;
  endtask

  // counts samples, starting with the current one, while the pin sits at lvl
  task automatic phase(input logic lvl, output int n);
    n = 0;
    while (pwm_out === lvl && n < 4000) begin
      n++;
      @(negedge clk);
      if (half) tick = ~tick;
    end
  endtask

  initial begin
    int n;
    do_reset();
    // R1
    chk("R1 pwm_out after reset", int'(pwm_out), 1);
    chk("R1 irq_pend after reset", int'(irq_pend), 0);

    // R3 R4 R5 R6 R10: vector table, software alternates lengths
    for (int v = 0; v < 6; v++) begin
      int on_l, off_l;
      on_l  = int'(VEC[v][15:8]);
      off_l = int'(VEC[v][7:0]);
      do_reset();
      preload(VEC[v][15:8], VEC[v][7:0]);
      run = 1'b1; tick = 1'b1;
      phase(1'b1, n);
      chk("R3 first high length", n, on_l + 1);
      chk("R6 irq set by underflow", int'(irq_pend), 1);
      rld_we = 1'b1; rld_wdata = VEC[v][15:8]; irq_clr = 1'b1;
      @(negedge clk);
      rld_we = 1'b0; irq_clr = 1'b0;
      if (off_l > 0) begin
        chk("R6 irq cleared", int'(irq_pend), 0);
        n = 0;
        phase(1'b0, n);
        chk("R5 R10 low length", n + 1, off_l + 1);
      end else begin
        chk("R6 set wins over clear", int'(irq_pend), 1);
        chk("R5 zero low length", int'(pwm_out), 1);
      end
      phase(1'b1, n);
      chk("R5 second high length", n, on_l + 1);
      run = 1'b0;
    end

    // R2: timer write on a zero count suppresses underflow
    do_reset();
    run = 1'b1; tick = 1'b1; tmr_we = 1'b1; tmr_wdata = 8'd2;
    @(negedge clk);
    tmr_we = 1'b0;
    chk("R2 no toggle on write cycle", int'(pwm_out), 1);
    phase(1'b1, n);
    chk("R2 high length after write", n + 1, 4);

    // R7: freeze while stopped, high and low
    do_reset();
    preload(8'd4, 8'd3);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7 pin held while stopped", int'(pwm_out), 1);
    chk("R7 no irq while stopped", int'(irq_pend), 0);
    run = 1'b1;
    phase(1'b1, n);
    chk("R7 frozen count kept", n, 5);
    run = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 low level held", int'(pwm_out), 0);
    run = 1'b1;
    phase(1'b0, n);
    chk("R7 low phase resumes", n, 4);

    // R8: tick every other cycle
    do_reset();
    preload(8'd3, 8'd1);
    half = 1'b1; run = 1'b1; tick = 1'b1;
    phase(1'b1, n);
    chk("R8 half-rate high length", n, 7);
    half = 1'b0;

    // R9: reload write in the underflow cycle
    do_reset();
    preload(8'd0, 8'd9);
    run = 1'b1; tick = 1'b1; rld_we = 1'b1; rld_wdata = 8'd2;
    @(negedge clk);
    rld_we = 1'b0;
    chk("R9 toggled at zero", int'(pwm_out), 0);
    phase(1'b0, n);
    chk("R9 low length from same-cycle write", n, 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule